// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block is the control and data path for one channel of a multi-channel SPI master. It holds the channel's configuration word, a three-flag status word, an enable bit, and one transmit and one receive data register. Software (or a DMA engine) starts word exchanges by loading transmit data or by taking receive data. Turning the channel on also starts one. Each attempt is weighed against the direction mode, the turbo bit and the current status flags before a word is shifted.

A built-in shift engine produces an active-low chip select that spans the whole word. It also produces a serial clock of the system clock divided by `2*HALF_DIV`, and MSB-first data on the output line. Input data is sampled on rising serial-clock edges and output data changes on falling ones. At the end of each exchange the block sets its flags and pulses interrupt-set lines toward a shared interrupt unit. It also drives a transmit and a receive DMA request level.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset the configuration reads 0x060000, the status reads 3'b010 (bit 0 receive-full, bit 1 transmit-empty, bit 2 end-of-transfer), enable is 0, chip select is high and all request and interrupt lines are low.
- R2: Word length is configuration bits 11:7 plus one. A word is sent MSB-first on `mosi` while `cs_n` stays low for exactly that many serial clock periods. The received word, MSB-first from `miso`, lands right-aligned in the receive register.
- R3: In full duplex (configuration bits 13:12 = 0), a completed exchange clears the transmit register and sets all three status flags. It pulses `irq_tx_set` and `irq_rx_set` for one cycle each.
- R4: Without turbo (configuration bit 19), an exchange attempt is held off while receive-full is set. Reading the receive register clears receive-full and retries the attempt.
- R5: With turbo set, an exchange runs even though receive-full is set, and its completion does not pulse `irq_rx_set`.
- R6: In transmit-only mode (bits 13:12 = 2), receive-full neither holds off an exchange nor is set by one, and `irq_rx_set` is not pulsed.
- R7: In receive-only mode (bits 13:12 = 1), transmit-empty does not hold off an exchange and `irq_tx_set` is not pulsed.
- R8: While the channel is disabled no exchange runs. Writing enable from 0 to 1 makes an exchange attempt.
- R9: When `single_chan` is 1 and the force bit (configuration bit 20) is 0, a permitted exchange shifts nothing and leaves the receive register unchanged, yet still updates the flags and clears the transmit register. With force set the word is shifted.
- R10: `dma_tx_req` is enable AND configuration bit 14 AND transmit-empty AND mode not 1. `dma_rx_req` is enable AND configuration bit 15 AND receive-full AND mode not 2. Each follows the state with one cycle of register delay.
- R11: An attempt that arrives during a shift is kept and re-evaluated when the shift ends. Transmit data written during a shift survives its completion, with transmit-empty left clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| single_chan | input | 1 | Module single-channel mode; shifting then requires the force bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 23 | Configuration write data |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write value |
| tx_we | input | 1 | Transmit register write strobe |
| tx_wdata | input | DW | Transmit write data |
| rx_re | input | 1 | Receive register read strobe (data valid in the same cycle) |
| cfg_q | output | 23 | Configuration register |
| stat_q | output | 3 | Status flags {end-of-transfer, transmit-empty, receive-full} |
| en_q | output | 1 | Channel enable |
| tx_q | output | DW | Transmit register |
| rx_q | output | DW | Receive register |
| irq_tx_set | output | 1 | One-cycle transmit interrupt set pulse |
| irq_rx_set | output | 1 | One-cycle receive interrupt set pulse |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Exchanges are run with word lengths of 4, 8, 16 and 32 bits and with distinct patterns on both lines, so a bit-order or alignment fault shows up in the scoreboard's captured word. The same write or read stimulus is repeated under each mode, with turbo on and off and with the channel disabled. This separates the three hold-off conditions: receive-full, transmit-empty and enable. Single-channel with and without force is tried to tell a flag-only completion from a real shift. A transmit write placed in the middle of a shift shows whether the kept attempt and its data survive the first completion.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CFG_W      = 23;
  localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;
  localparam int WL_W       = 6;
  localparam int WL_LSB     = 7;
  localparam int MODE_LSB   = 12;
  localparam int DMATX_BIT  = 14;
  localparam int DMARX_BIT  = 15;
  localparam int TURBO_BIT  = 19;
  localparam int FORCE_BIT  = 20;
  localparam int ST_RXF     = 0;
  localparam int ST_TXE     = 1;
  localparam int ST_EOT     = 2;

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_RXONLY = 2'd1,
    XM_TXONLY = 2'd2,
    XM_BAD    = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/spi_xfer_gate.sv
module spi_xfer_gate
  import spi_seq_pkg::*;
(
  input  logic       en,
  input  logic       rxf,
  input  logic       txe,
  input  xfer_mode_e mode,
  input  logic       turbo,
  input  logic       single_chan,
  input  logic       force_sh,
  output logic       go,
  output logic       do_shift
);
  logic rx_block, tx_block;

  always_comb begin
    rx_block = rxf && !turbo && (mode != XM_TXONLY);
    tx_block = txe && (mode != XM_RXONLY);
    go       = en && !rx_block && !tx_block;
    do_shift = !single_chan || force_sh;
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_seq_pkg::*;
#(
  parameter int DW       = 32,
  parameter int HALF_DIV = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [WL_W-1:0] wl,
  input  logic [DW-1:0]   tx_word,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rx_word,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0]   tx_sh, rx_sh;
  logic [WL_W-1:0] bit_idx, wl_q;
  logic [CW-1:0]   div_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bit_idx <= '0;
      wl_q    <= '0;
      div_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          tx_sh   <= tx_word << (DW - int'(wl));
          rx_sh   <= '0;
          bit_idx <= '0;
          wl_q    <= wl;
          div_cnt <= '0;
        end
      end else if (int'(div_cnt) == HALF_DIV - 1) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[DW-2:0], miso};
        end else begin
          sclk  <= 1'b0;
          tx_sh <= tx_sh << 1;
          if (bit_idx == wl_q - 1'b1) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            done <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign mosi    = tx_sh[DW-1];
  assign rx_word = rx_sh;

  // R2
  cs_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> (bit_idx < wl_q));
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
endmodule

// File: rtl/spi_req_out.sv
module spi_req_out
  import spi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done_now,
  input  logic       keep_tx,
  input  logic       en,
  input  logic       dma_tx_en,
  input  logic       dma_rx_en,
  input  logic       txe,
  input  logic       rxf,
  input  xfer_mode_e mode,
  input  logic       turbo,
  output logic       irq_tx_set,
  output logic       irq_rx_set,
  output logic       dma_tx_req,
  output logic       dma_rx_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_tx_set <= 1'b0;
      irq_rx_set <= 1'b0;
      dma_tx_req <= 1'b0;
      dma_rx_req <= 1'b0;
    end else begin
      irq_tx_set <= done_now && !keep_tx && (mode != XM_RXONLY);
      irq_rx_set <= done_now && !turbo && (mode != XM_TXONLY);
      dma_tx_req <= en && dma_tx_en && txe && (mode != XM_RXONLY);
      dma_rx_req <= en && dma_rx_en && rxf && (mode != XM_TXONLY);
    end
  end
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_seq_pkg::*;
#(
  parameter int DW       = 32,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             single_chan,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             en_we,
  input  logic             en_wdata,
  input  logic             tx_we,
  input  logic [DW-1:0]    tx_wdata,
  input  logic             rx_re,
  output logic [CFG_W-1:0] cfg_q,
  output logic [2:0]       stat_q,
  output logic             en_q,
  output logic [DW-1:0]    tx_q,
  output logic [DW-1:0]    rx_q,
  output logic             irq_tx_set,
  output logic             irq_rx_set,
  output logic             dma_tx_req,
  output logic             dma_rx_req,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  logic [CFG_W-1:0] cfg_r;
  logic [2:0]       stat_r;
  logic             en_r, pend_r, fresh_r;
  logic [DW-1:0]    tx_r, rx_r, sh_rx;
  logic             sh_busy, sh_done, go, do_shift;
  logic             attempt, eval, start_shift, done_now, keep_tx;
  logic [WL_W-1:0]  wl;
  xfer_mode_e       mode;

  assign mode = xfer_mode_e'(cfg_r[MODE_LSB +: 2]);
  assign wl   = {1'b0, cfg_r[WL_LSB +: 5]} + 1'b1;

  spi_xfer_gate u_gate (
    .en(en_r), .rxf(stat_r[ST_RXF]), .txe(stat_r[ST_TXE]), .mode(mode),
    .turbo(cfg_r[TURBO_BIT]), .single_chan(single_chan),
    .force_sh(cfg_r[FORCE_BIT]), .go(go), .do_shift(do_shift)
  );

  assign attempt     = tx_we || rx_re || (en_we && en_wdata && !en_r);
  assign eval        = pend_r && !sh_busy;
  assign start_shift = eval && go && do_shift;
  assign done_now    = (eval && go && !do_shift) || sh_done;
  assign keep_tx     = sh_done && fresh_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r   <= CFG_RST;
      stat_r  <= 3'b010;
      en_r    <= 1'b0;
      tx_r    <= '0;
      rx_r    <= '0;
      pend_r  <= 1'b0;
      fresh_r <= 1'b0;
    end else begin
      if (cfg_we) cfg_r <= cfg_wdata;
      if (en_we)  en_r  <= en_wdata;
      pend_r <= attempt || (pend_r && sh_busy);
      if (start_shift)  fresh_r <= tx_we;
      else if (tx_we)   fresh_r <= 1'b1;
      if (rx_re) stat_r[ST_RXF] <= 1'b0;
      if (done_now) begin
        stat_r[ST_EOT] <= 1'b1;
        if (!keep_tx) begin
          stat_r[ST_TXE] <= 1'b1;
          tx_r           <= '0;
        end
        if (mode != XM_TXONLY) stat_r[ST_RXF] <= 1'b1;
        if (sh_done) rx_r <= sh_rx;
      end
      if (tx_we) begin
        tx_r           <= tx_wdata;
        stat_r[ST_TXE] <= 1'b0;
      end
    end
  end

  spi_word_shifter #(.DW(DW), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(start_shift), .wl(wl), .tx_word(tx_r),
    .miso(miso), .busy(sh_busy), .done(sh_done), .rx_word(sh_rx),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
  );

  spi_req_out u_req (
    .clk(clk), .rst(rst), .done_now(done_now), .keep_tx(keep_tx),
    .en(en_r), .dma_tx_en(cfg_r[DMATX_BIT]), .dma_rx_en(cfg_r[DMARX_BIT]),
    .txe(stat_r[ST_TXE]), .rxf(stat_r[ST_RXF]), .mode(mode),
    .turbo(cfg_r[TURBO_BIT]), .irq_tx_set(irq_tx_set),
    .irq_rx_set(irq_rx_set), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  assign cfg_q  = cfg_r;
  assign stat_q = stat_r;
  assign en_q   = en_r;
  assign tx_q   = tx_r;
  assign rx_q   = rx_r;

  // R3
  eot_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_now |=> stat_r[ST_EOT]);
  // R8
  start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sh_busy) |-> $past(en_r));
  // R11
  latch_attempt_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_busy && tx_we) |=> pend_r);
  // R3
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    sh_done |-> !sh_busy);
endmodule

// File: tb/test_spi_chan_seq.sv
module test_spi_chan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int HD = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic single_chan = 1'b0;
  logic cfg_we = 1'b0, en_we = 1'b0, en_wdata = 1'b0, tx_we = 1'b0, rx_re = 1'b0;
  logic [22:0] cfg_wdata = '0;
  logic [DW-1:0] tx_wdata = '0;
  logic [22:0] cfg_q;
  logic [2:0] stat_q;
  logic en_q, irq_tx_set, irq_rx_set, dma_tx_req, dma_rx_req, sclk, cs_n, mosi;
  logic miso;
  logic [DW-1:0] tx_q, rx_q;

  int errors = 0, checks = 0, xfer_cnt = 0, irq_tx_cnt = 0, irq_rx_cnt = 0;
  bit finished = 0;

  typedef struct { logic [31:0] mosi_w; logic [31:0] miso_w; int wl; } item_t;
  item_t sb_q[$];
  item_t cur;
  logic [31:0] slave_sh, cap;
  int cap_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chan_seq #(.DW(DW), .HALF_DIV(HD)) i_spi_chan_seq (
    .clk(clk), .rst(rst), .single_chan(single_chan), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .en_we(en_we), .en_wdata(en_wdata), .tx_we(tx_we),
    .tx_wdata(tx_wdata), .rx_re(rx_re), .cfg_q(cfg_q), .stat_q(stat_q),
    .en_q(en_q), .tx_q(tx_q), .rx_q(rx_q), .irq_tx_set(irq_tx_set),
    .irq_rx_set(irq_rx_set), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  assign miso = slave_sh[31];

  // monitor: slave model and scoreboard
  always @(negedge cs_n) begin
    xfer_cnt++;
    cap = '0;
    cap_bits = 0;
    if (sb_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R2: unexpected exchange actual=1 expected=0");
      cur.wl = 32; cur.mosi_w = '0; cur.miso_w = '0;
    end else begin
      cur = sb_q.pop_front();
    end
    slave_sh = cur.miso_w << (32 - cur.wl);
  end
  always @(posedge sclk) begin
    cap = {cap[30:0], mosi};
    cap_bits++;
  end
  always @(negedge sclk) if (!cs_n) slave_sh = slave_sh << 1;
  always @(posedge cs_n) if (!rst) begin
    check("R2 mosi word", cap, cur.mosi_w);
    check("R2 bit count", cap_bits, cur.wl);
  end

  always @(negedge clk) begin
    if (irq_tx_set) irq_tx_cnt++;
    if (irq_rx_set) irq_rx_cnt++;
  end

  task automatic expect_x(logic [31:0] m, logic [31:0] s, int wl);
    item_t it;
    it.mosi_w = m; it.miso_w = s; it.wl = wl;
    sb_q.push_back(it);
  endtask

  task automatic wr_cfg(logic [22:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_en(logic v);
    @(negedge clk); en_we = 1; en_wdata = v;
    @(negedge clk); en_we = 0;
  endtask
  task automatic wr_tx(logic [31:0] v);
    @(negedge clk); tx_we = 1; tx_wdata = v;
    @(negedge clk); tx_we = 0;
  endtask
  task automatic rd_rx(output logic [31:0] v);
    @(negedge clk); rx_re = 1; v = rx_q;
    @(negedge clk); rx_re = 0;
  endtask
  task automatic settle(int wl);
    repeat (2*wl*HD + 8) @(negedge clk);
  endtask

  function automatic logic [22:0] mk_cfg(int wl, int mode, bit turbo, bit frc,
                                         bit dtx, bit drx);
    logic [22:0] c;
    c = 23'h060000;
    c[11:7] = 5'(wl - 1);
    c[13:12] = 2'(mode);
    c[14] = dtx; c[15] = drx; c[19] = turbo; c[20] = frc;
    return c;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] rd;
    int xc, it, ir;
    slave_sh = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg", cfg_q, 32'h060000);
    check("R1 stat", stat_q, 3'b010);
    check("R1 en", en_q, 0);
    check("R1 cs_n", cs_n, 1);
    check("R1 dma", {dma_tx_req, dma_rx_req, irq_tx_set, irq_rx_set}, 0);

    // R2/R3/R10: full duplex 8 bit, tx DMA enabled
    wr_cfg(mk_cfg(8, 0, 0, 0, 1, 0));
    wr_en(1);
    repeat (3) @(negedge clk);
    check("R10 tx dma high", dma_tx_req, 1);
    check("R8 no exchange while tx empty", xfer_cnt, 0);
    it = irq_tx_cnt; ir = irq_rx_cnt;
    expect_x(32'hA5, 32'h3C, 8);
    wr_tx(32'hA5);
    @(negedge clk);
    check("R10 tx dma low while loaded", dma_tx_req, 0);
    settle(8);
    check("R2 rx data", rx_q, 32'h3C);
    check("R3 stat", stat_q, 3'b111);
    check("R3 tx cleared", tx_q, 0);
    check("R3 tx irq", irq_tx_cnt, it + 1);
    check("R3 rx irq", irq_rx_cnt, ir + 1);

    // R4: receive-full holds off
    xc = xfer_cnt;
    wr_tx(32'h11);
    settle(8);
    check("R4 held", xfer_cnt, xc);
    check("R4 stat", stat_q, 3'b101);
    expect_x(32'h11, 32'h80, 8);
    rd_rx(rd);
    check("R4 read data", rd, 32'h3C);
    settle(8);
    check("R4 released", xfer_cnt, xc + 1);
    check("R4 rx data", rx_q, 32'h80);

    // R10: rx DMA
    wr_cfg(mk_cfg(8, 0, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    check("R10 rx dma high", dma_rx_req, 1);
    wr_cfg(mk_cfg(8, 2, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    check("R10 rx dma off in tx-only", dma_rx_req, 0);

    // R5: turbo, 16 bit
    wr_cfg(mk_cfg(16, 0, 1, 0, 0, 0));
    it = irq_tx_cnt; ir = irq_rx_cnt;
    expect_x(32'hBEEF, 32'h1234, 16);
    wr_tx(32'hBEEF);
    settle(16);
    check("R5 rx data", rx_q, 32'h1234);
    check("R5 no rx irq", irq_rx_cnt, ir);
    check("R5 tx irq", irq_tx_cnt, it + 1);

    // R6: transmit-only, 32 bit
    wr_cfg(mk_cfg(32, 2, 0, 0, 0, 0));
    rd_rx(rd);
    it = irq_tx_cnt; ir = irq_rx_cnt;
    expect_x(32'hDEADBEEF, 32'hCAFEF00D, 32);
    wr_tx(32'hDEADBEEF);
    settle(32);
    check("R6 stat", stat_q, 3'b110);
    check("R6 rx data", rx_q, 32'hCAFEF00D);
    check("R6 no rx irq", irq_rx_cnt, ir);
    check("R6 tx irq", irq_tx_cnt, it + 1);

    // R7: receive-only, 4 bit
    wr_en(0);
    wr_cfg(mk_cfg(4, 1, 0, 0, 0, 0));
    it = irq_tx_cnt; ir = irq_rx_cnt;
    expect_x(32'h0, 32'h9, 4);
    wr_en(1);
    settle(4);
    check("R7 rx data", rx_q, 32'h9);
    check("R7 rx full", stat_q[0], 1);
    check("R7 no tx irq", irq_tx_cnt, it);
    check("R7 rx irq", irq_rx_cnt, ir + 1);
    expect_x(32'h0, 32'h6, 4);
    rd_rx(rd);
    settle(4);
    check("R7 second rx", rx_q, 32'h6);

    // R8: disabled
    wr_en(0);
    wr_cfg(mk_cfg(8, 0, 0, 0, 0, 0));
    rd_rx(rd);
    xc = xfer_cnt;
    wr_tx(32'h55);
    settle(8);
    check("R8 disabled no exchange", xfer_cnt, xc);
    check("R8 tx kept", tx_q, 32'h55);
    expect_x(32'h55, 32'hAA, 8);
    wr_en(1);
    settle(8);
    check("R8 enable starts", xfer_cnt, xc + 1);
    check("R8 rx data", rx_q, 32'hAA);

    // R9: single-channel without force
    single_chan = 1;
    rd_rx(rd);
    xc = xfer_cnt;
    wr_tx(32'h77);
    settle(8);
    check("R9 no shift", xfer_cnt, xc);
    check("R9 stat", stat_q, 3'b111);
    check("R9 rx unchanged", rx_q, 32'hAA);
    check("R9 tx cleared", tx_q, 0);
    wr_cfg(mk_cfg(8, 0, 0, 1, 0, 0));
    rd_rx(rd);
    expect_x(32'h42, 32'h24, 8);
    wr_tx(32'h42);
    settle(8);
    check("R9 force shifts", rx_q, 32'h24);
    single_chan = 0;

    // R11: write during shift
    wr_cfg(mk_cfg(8, 0, 1, 0, 0, 0));
    xc = xfer_cnt;
    expect_x(32'h01, 32'hF0, 8);
    expect_x(32'h02, 32'h0F, 8);
    wr_tx(32'h01);
    repeat (5) @(negedge clk);
    wr_tx(32'h02);
    check("R11 tx during shift", tx_q, 32'h02);
    settle(8);
    settle(8);
    check("R11 two exchanges", xfer_cnt, xc + 2);
    check("R11 rx data", rx_q, 32'h0F);
    check("R11 tx cleared", tx_q, 0);
    check("R2 scoreboard drained", sb_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule